// File: doc/BRIEF.md
# Card Slot Selector with Serial-Engine Reset Gate

This block is the control register that sits in front of a shared serial engine serving three card slots. Software reaches it through a simple register port. It writes one byte that says which slot the engine serves, and that byte also says whether the engine may leave reset. The selection is driven out as a one-hot slot select. The release bit gates a reset output that holds every register of the serial engine at its initial value until software sets the bit.

The register checks every write before it changes the selection. The third slot is accepted only while slot 1 or slot 2 reports that it is activated. A write that names more than one slot is refused. A refused write keeps the previous selection, but its release bit still takes effect. Reads are registered: the byte appears on the read-data port one cycle after the read strobe and is held until the next read.

Top module: `slot_sel_ctrl`

## Requirements
- R1: The register sits at address 0. Bit 0 selects slot 1, bit 1 selects slot 2, bit 2 selects slot 3 and bit 3 is the engine release. When `bus_rd` is sampled high at a clock edge, `bus_rdata` takes the register value after that edge (the value from before any write at the same edge), or 0 for any other address. Without `bus_rd`, `bus_rdata` holds its value.
- R2: While `rst_n` is low and after it is released, `slot_sel` is 3'b001, the release bit is 0 and `bus_rdata` is 0.
- R3: A write whose bits 2..0 have more than one bit set leaves `slot_sel` unchanged, so `slot_sel` is never more than one-hot.
- R4: `eng_rst` is 1 whenever the release bit is 0 or `rst_n` is low. It is 0 only while the release bit is 1.
- R5: A write that selects slot 3 (bits 2..0 = 3'b100) while both bits of `slot_active` are 0 leaves `slot_sel` unchanged.
- R6: Cycles with no write, and writes to any address other than 0, leave `slot_sel` and the release bit unchanged.
- R7: Register bits 7..4 always read as 0.
- R8: Every write to address 0 loads bit 3 into the release bit, including writes whose selection is refused.
- R9: A write with bits 2..0 = 3'b000 is accepted and deselects every slot (`slot_sel` = 3'b000).
- R10: An accepted write with one select bit set drives that slot on `slot_sel` from the edge that samples the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| slot_active | input | 2 | Activated status of slot 1 (bit 0) and slot 2 (bit 1) |
| slot_sel | output | 3 | One-hot slot select, bit n for slot n+1 |
| eng_rst | output | 1 | Reset for the serial engine, high while held |

## Verification
The assertions check on every cycle that the selection never has more than one slot, that slot 3 never rises unless a slot was active in the cycle before, that idle cycles change neither the selection nor the read data, that unused bits read zero, and that a write clearing the release bit is followed by the engine reset. The bench scenarios show the rest: the exact value after reset, that a refused write still updates the release bit, that reads at the same edge as a write return the old value, that an all-zero selection is accepted, and that reads at other addresses return zero. These are checked by comparing the ports with a reference model under random and directed traffic.

// File: rtl/slotsel_pkg.sv
package slotsel_pkg;
  localparam int unsigned SLOTS   = 3;
  localparam int unsigned REL_BIT = SLOTS;

  typedef struct packed {
    logic             rel;
    logic [SLOTS-1:0] sel;
  } ctl_word_t;

  localparam ctl_word_t CTL_RESET = '{rel: 1'b0, sel: 3'b001};
endpackage

// File: rtl/slotsel_guard.sv
module slotsel_guard
  import slotsel_pkg::*;
#(
  parameter int unsigned NSLOT = SLOTS
) (
  input  logic [NSLOT-1:0] req_sel,
  input  logic [NSLOT-2:0] slot_active,
  output logic             accept
);
  localparam int unsigned CNT_W = $clog2(NSLOT + 1);

  logic [CNT_W-1:0] n_set;
  logic             one_or_none;
  logic             last_ok;

  always_comb begin
    n_set = '0;
    for (int i = 0; i < NSLOT; i++) begin
      n_set = n_set + CNT_W'(req_sel[i]);
    end
  end

  assign one_or_none = (n_set <= CNT_W'(1));
  // the highest slot may be served only behind an activated lower slot
  assign last_ok     = !req_sel[NSLOT-1] || (|slot_active);
  assign accept      = one_or_none && last_ok;
endmodule

// File: rtl/slotsel_regs.sv
module slotsel_regs
  import slotsel_pkg::*;
#(
  parameter int unsigned NSLOT = SLOTS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hit,
  input  logic [NSLOT-1:0] wr_sel,
  input  logic             wr_rel,
  input  logic             accept,
  input  logic [NSLOT-2:0] slot_active,
  output logic [NSLOT-1:0] sel_q,
  output logic             rel_q
);
  localparam logic [NSLOT-1:0] SEL_INIT = NSLOT'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= SEL_INIT;
      rel_q <= 1'b0;
    end else if (wr_hit) begin
      rel_q <= wr_rel;
      if (accept) sel_q <= wr_sel;
    end
  end

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_q)); // R3
  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> ($stable(sel_q) && $stable(rel_q))); // R6
  AST_TOP_SLOT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_q[NSLOT-1]) |-> $past(|slot_active)); // R5
endmodule

// File: rtl/slotsel_rdport.sv
module slotsel_rdport
  import slotsel_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NSLOT  = SLOTS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              rd_hit,
  input  logic [NSLOT-1:0]  sel_q,
  input  logic              rel_q,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned USED_W = NSLOT + 1;

  logic [DATA_W-1:0] word;
  assign word = {{(DATA_W-USED_W){1'b0}}, rel_q, sel_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_hit ? word : '0;
  end

  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[DATA_W-1:USED_W] == '0); // R7
  AST_RD_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata)); // R1
endmodule

// File: rtl/slot_sel_ctrl.sv
module slot_sel_ctrl
  import slotsel_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned NSLOT    = SLOTS,
  parameter int unsigned REG_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NSLOT-2:0]  slot_active,
  output logic [NSLOT-1:0]  slot_sel,
  output logic              eng_rst
);
  localparam int unsigned RELEASE_POS = NSLOT;

  logic             addr_hit;
  logic             wr_hit;
  logic             accept;
  logic [NSLOT-1:0] sel_q;
  logic             rel_q;
  logic             unused_wbits;

  assign addr_hit     = (bus_addr == ADDR_W'(REG_ADDR));
  assign wr_hit       = bus_wr && addr_hit;
  assign unused_wbits = ^bus_wdata[DATA_W-1:RELEASE_POS+1];

  slotsel_guard #(.NSLOT(NSLOT)) guard_i (
    .req_sel     (bus_wdata[NSLOT-1:0]),
    .slot_active (slot_active),
    .accept      (accept)
  );

  slotsel_regs #(.NSLOT(NSLOT)) regs_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_hit      (wr_hit),
    .wr_sel      (bus_wdata[NSLOT-1:0]),
    .wr_rel      (bus_wdata[RELEASE_POS]),
    .accept      (accept),
    .slot_active (slot_active),
    .sel_q       (sel_q),
    .rel_q       (rel_q)
  );

  slotsel_rdport #(.DATA_W(DATA_W), .NSLOT(NSLOT)) rdport_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_en  (bus_rd),
    .rd_hit (addr_hit),
    .sel_q  (sel_q),
    .rel_q  (rel_q),
    .rdata  (bus_rdata)
  );

  assign slot_sel = sel_q;
  assign eng_rst  = !rst_n || !rel_q;

  AST_LOCK_HOLDS_RST: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !bus_wdata[RELEASE_POS]) |=> eng_rst); // R4
  AST_FREE_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && bus_wdata[RELEASE_POS]) |=> !eng_rst); // R8
endmodule

// File: tb/slot_sel_ctrl_tb.sv
module slot_sel_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic [1:0] slot_active = '0;
  logic [2:0] slot_sel;
  logic       eng_rst;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [2:0] m_sel = 3'b001;
  logic       m_rel = 1'b0;
  logic [7:0] m_rdata = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  slot_sel_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .slot_active(slot_active), .slot_sel(slot_sel), .eng_rst(eng_rst)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WATCHDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic sel_ok(logic [2:0] req, logic [1:0] act);
    return ($countones(req) <= 1) && !(req[2] && act == 2'b00);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_all(string req);
    chk(req, 32'(slot_sel), 32'(m_sel));
    chk(req, 32'(eng_rst), 32'(!m_rel));
    chk(req, 32'(bus_rdata), 32'(m_rdata));
  endtask

  // called at a negedge; returns at the following negedge
  task automatic step(logic wr, logic rd, logic [3:0] a, logic [7:0] d,
                      logic [1:0] act, string req);
    logic hit;
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d; slot_active = act;
    @(posedge clk);
    hit = (a == 4'd0);
    if (rd) m_rdata = hit ? {4'b0000, m_rel, m_sel} : 8'h00;
    if (wr && hit) begin
      m_rel = d[3];
      if (sel_ok(d[2:0], act)) m_sel = d[2:0];
    end
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    check_all(req);
  endtask

  initial begin
    void'($urandom(32'd20240517));
    @(negedge clk);
    // R2: state while reset held
    check_all("R2");
    chk("R4", 32'(eng_rst), 32'd1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R2");
    step(0, 1, 4'd0, 8'h00, 2'b00, "R1");
    chk("R2", 32'(bus_rdata), 32'h01);
    step(1, 0, 4'd0, 8'h0A, 2'b00, "R10");        // select slot 2, release
    chk("R4", 32'(eng_rst), 32'd0);
    step(1, 0, 4'd0, 8'h0C, 2'b00, "R5");         // slot 3 refused
    chk("R5", 32'(slot_sel), 32'b010);
    step(1, 0, 4'd0, 8'h03, 2'b11, "R3");         // two bits, refused, release cleared
    chk("R8", 32'(eng_rst), 32'd1);
    step(1, 0, 4'd0, 8'h0C, 2'b01, "R5");         // slot 3 allowed
    chk("R5", 32'(slot_sel), 32'b100);
    step(1, 0, 4'd5, 8'h01, 2'b01, "R6");         // wrong address
    step(0, 1, 4'd5, 8'h00, 2'b00, "R1");         // read elsewhere = 0
    step(1, 1, 4'd0, 8'hF8, 2'b00, "R9");         // zero select, old value read
    chk("R7", 32'(bus_rdata[7:4]), 32'd0);
    step(0, 1, 4'd0, 8'h00, 2'b00, "R7");
    chk("R9", 32'(slot_sel), 32'b000);
    step(1, 0, 4'd0, 8'h07, 2'b10, "R8");         // refused, release 0
    for (int i = 0; i < 400; i++) begin
      logic [7:0] d;
      d = 8'($urandom);
      step(1'($urandom), 1'($urandom), (($urandom % 3) == 0) ? 4'($urandom) : 4'd0,
           d, 2'($urandom), "R10");
    end
    // R2: reset in mid-run
    bus_wr = 1'b1; bus_wdata = 8'h0A; bus_addr = 4'd0;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
    rst_n = 1'b0;
    m_sel = 3'b001; m_rel = 1'b0; m_rdata = 8'h00;
    #1;
    check_all("R2");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R2");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule